// File: doc/BRIEF.md
# I/O Page Translation Unit

This block turns DMA bus addresses issued by devices into system physical addresses. It keeps an on-chip array of 64-bit translation entries, one for each I/O page of a window. A request carries an address and a direction flag. One cycle after the request is accepted, the block returns four things: the physical address, the mask of the offset bits that pass through unchanged, the access rights from the entry, and a fault flag.

The page size is a power of two chosen at run time through a shift input. The number of valid entries is also chosen at run time. A count of zero disables the window. A plain write port fills the array. After reset every entry is cleared, so every page faults until software programs it. Results leave through a valid/ready register stage, so a stalled consumer holds the result in place and stalls the request side.

Top module: `tce_xlate`

## Requirements
- R1: After reset, rsp_valid is low and req_ready is high. Reset clears every table entry to zero, so a request to any in-range page then returns rights 0 and fault 1.
- R2: Bits [1:0] of an entry hold the rights, and rsp_perm reports them: 0 = none, 1 = read only, 2 = write only, 3 = read and write.
- R3: The entry used for a request is the one at index req_addr >> cfg_shift.
- R4: When the page index is not below cfg_count, or not below the table depth, the response has rsp_perm 0, rsp_mask all ones, rsp_addr 0 and rsp_fault 1.
- R5: For an in-range request, rsp_mask is 2^cfg_shift - 1. rsp_addr is the entry with its low cfg_shift bits cleared, OR'd with the low cfg_shift bits of req_addr.
- R6: rsp_fault is 1 when the rights are 0, when req_write=1 meets read-only rights, or when req_write=0 meets write-only rights. In every other case it is 0.
- R7: While cfg_count is 0, every request faults with the R4 response.
- R8: A request is accepted when req_valid and req_ready are both high. Its response shows on rsp_valid one cycle later. req_ready equals !rsp_valid || rsp_ready. While rsp_valid is high and rsp_ready is low, the response stays valid and unchanged.
- R9: Changing cfg_shift at run time changes both the page index and the mask. For example, with shift 16 a request maps through entry req_addr >> 16 and gets mask 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 6 | log2 of the I/O page size |
| cfg_count | input | CNT_W | Number of valid entries in the window (0 disables it) |
| upd_en | input | 1 | Table write strobe |
| upd_idx | input | IDX_W | Table write index |
| upd_data | input | 64 | Table write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 64 | Bus address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 64 | Translated physical address |
| rsp_mask | output | 64 | Page offset mask |
| rsp_perm | output | 2 | Rights from the entry |
| rsp_fault | output | 1 | Access refused |

## Verification
The translation is tried with four entries that carry each of the four rights codes, read and written in turn. This separates the two direction-dependent faults from the always-fault and never-fault cases. Requests at index count-1, at count, and far above the window separate the last valid page from the first invalid one. Requests after a count of zero and after a second reset separate a disabled window and a cleared table from live entries. Running the same address at shift 12 and at shift 16 shows whether both the index and the mask follow the shift. A request is also held back behind a stalled response, which shows the result staying in place and the next request being taken on the cycle the stall ends.

// File: rtl/tce_pkg.sv
package tce_pkg;

    localparam int ADDR_W  = 64;
    localparam int ENTRY_W = 64;
    localparam int SHIFT_W = 6;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_WO   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef struct packed {
        logic [ADDR_W-1:0] phys;
        logic [ADDR_W-1:0] mask;
        perm_e             perm;
        logic              fault;
    } xlate_res_t;

    // Offset mask for a page of 2^shift bytes
    function automatic logic [ADDR_W-1:0] offset_mask(input logic [SHIFT_W-1:0] shift);
        return (ADDR_W'(1) << shift) - ADDR_W'(1);
    endfunction

    // Whether the rights refuse this direction
    function automatic logic denied(input perm_e perm, input logic is_write);
        case (perm)
            PERM_NONE: return 1'b1;
            PERM_RO:   return is_write;
            PERM_WO:   return !is_write;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tce_table.sv
module tce_table #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [tce_pkg::ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [tce_pkg::ENTRY_W-1:0] rd_data
);
    logic [tce_pkg::ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/tce_lookup.sv
module tce_lookup
    import tce_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               is_write,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CNT_W-1:0]   count,
    output logic [IDX_W-1:0]   idx,
    input  logic [ENTRY_W-1:0] entry,
    output xlate_res_t         res
);
    logic [ADDR_W-1:0] page;
    logic [ADDR_W-1:0] mask;
    logic              in_window;
    perm_e             perm;

    always_comb begin
        page      = addr >> shift;
        mask      = offset_mask(shift);
        in_window = (page < ADDR_W'(count)) && (page < ADDR_W'(DEPTH));
        idx       = page[IDX_W-1:0];
        perm      = perm_e'(entry[1:0]);
        if (in_window) begin
            res.phys  = (entry & ~mask) | (addr & mask);
            res.mask  = mask;
            res.perm  = perm;
            res.fault = denied(perm, is_write);
        end else begin
            res.phys  = '0;
            res.mask  = '1;
            res.perm  = PERM_NONE;
            res.fault = 1'b1;
        end
    end
endmodule

// File: rtl/tce_rsp_stage.sv
module tce_rsp_stage
    import tce_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  xlate_res_t in_res,
    output logic       out_valid,
    input  logic       out_ready,
    output xlate_res_t out_res
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_res <= in_res;
        end
    end
endmodule

// File: rtl/tce_xlate.sv
module tce_xlate
    import tce_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               upd_en,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic [ENTRY_W-1:0] upd_data,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic [ADDR_W-1:0]  rsp_mask,
    output logic [1:0]         rsp_perm,
    output logic               rsp_fault
);
    logic [IDX_W-1:0]   rd_idx;
    logic [ENTRY_W-1:0] rd_entry;
    xlate_res_t         look_res;
    xlate_res_t         held_res;

    tce_table #(.DEPTH(DEPTH)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (upd_en),
        .wr_idx (upd_idx),
        .wr_data(upd_data),
        .rd_idx (rd_idx),
        .rd_data(rd_entry)
    );

    tce_lookup #(.DEPTH(DEPTH)) u_lookup (
        .addr    (req_addr),
        .is_write(req_write),
        .shift   (cfg_shift),
        .count   (cfg_count),
        .idx     (rd_idx),
        .entry   (rd_entry),
        .res     (look_res)
    );

    tce_rsp_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_res   (look_res),
        .out_valid(rsp_valid),
        .out_ready(rsp_ready),
        .out_res  (held_res)
    );

    assign rsp_addr  = held_res.phys;
    assign rsp_mask  = held_res.mask;
    assign rsp_perm  = held_res.perm;
    assign rsp_fault = held_res.fault;
endmodule

// File: rtl/tce_xlate_chk.sv
module tce_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_addr,
    input logic [63:0] rsp_mask,
    input logic [1:0]  rsp_perm,
    input logic        rsp_fault
);
    logic [63:0] last_addr;

    always_ff @(posedge clk) begin
        if (rst) last_addr <= '0;
        else if (req_valid && req_ready) last_addr <= req_addr;
    end

    // R8: an accepted request yields a response on the next cycle
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> rsp_valid);

    // R8: a stalled response holds its value
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_mask)
                                    && $stable(rsp_perm) && $stable(rsp_fault));

    // R8: an empty output stage always takes a request
    p_ready_r8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> req_ready);

    // R4: a window miss carries no rights, a zero address and a fault
    p_miss_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_mask == '1) |-> rsp_perm == 2'd0 && rsp_addr == '0 && rsp_fault);

    // R5: a hit mask is one below a power of two, and the offset bits pass through
    p_offset_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_mask != '1) |-> $countones(rsp_mask + 64'd1) == 1
                                          && ((rsp_addr ^ last_addr) & rsp_mask) == '0);

    // R6: no rights always faults
    p_none_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_perm == 2'd0 |-> rsp_fault);

    // R6: full rights never fault
    p_rw_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_perm == 2'd3 |-> !rsp_fault);
endmodule

bind tce_xlate tce_xlate_chk u_chk (.*);

// File: tb/test_tce_xlate.sv
module test_tce_xlate;
    localparam int DEPTH = 64;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic [5:0]       cfg_shift;
    logic [CNT_W-1:0] cfg_count;
    logic             upd_en;
    logic [IDX_W-1:0] upd_idx;
    logic [63:0]      upd_data;
    logic             req_valid, req_ready, req_write;
    logic [63:0]      req_addr;
    logic             rsp_valid, rsp_ready;
    logic [63:0]      rsp_addr, rsp_mask;
    logic [1:0]       rsp_perm;
    logic             rsp_fault;

    int checks = 0;
    int errors = 0;
    logic [63:0] shadow [DEPTH];

    always #10 clk = ~clk;

    tce_xlate #(.DEPTH(DEPTH)) i_tce_xlate (.*);

    task automatic check(input string req, input logic ok, input string got, input string want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", req, got, want);
        end
    endtask

    task automatic check_rsp(input string req, input logic [63:0] ea, input logic [63:0] em,
                             input logic [1:0] ep, input logic ef);
        check(req, rsp_valid && rsp_addr == ea && rsp_mask == em && rsp_perm == ep && rsp_fault == ef,
              $sformatf("v=%0b a=%h m=%h p=%0d f=%0b", rsp_valid, rsp_addr, rsp_mask, rsp_perm, rsp_fault),
              $sformatf("v=1 a=%h m=%h p=%0d f=%0b", ea, em, ep, ef));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    endtask

    task automatic put(input int idx, input logic [63:0] data);
        @(negedge clk);
        upd_en = 1'b1; upd_idx = IDX_W'(idx); upd_data = data;
        @(negedge clk);
        upd_en = 1'b0;
        shadow[idx] = data;
    endtask

    // Send one request and compare with the model derived from the requirements
    task automatic xlate(input string req, input logic [63:0] a, input logic w);
        logic [63:0] pg, m, ea;
        logic [1:0]  ep;
        logic        ef;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        pg = a >> cfg_shift;
        m  = (64'd1 << cfg_shift) - 64'd1;
        if (pg >= 64'(cfg_count) || pg >= 64'(DEPTH)) begin
            ea = '0; m = '1; ep = 2'd0; ef = 1'b1;
        end else begin
            ea = (shadow[pg] & ~m) | (a & m);
            ep = shadow[pg][1:0];
            ef = (ep == 2'd0) || (w && ep == 2'd1) || (!w && ep == 2'd2);
        end
        check_rsp(req, ea, m, ep, ef);
    endtask

    task automatic t_reset();
        check("R1 idle", !rsp_valid && req_ready, $sformatf("v=%0b r=%0b", rsp_valid, req_ready), "v=0 r=1");
        xlate("R1 cleared entry", 64'h0000_0000_0000_0123, 1'b0);
        put(1, 64'h0000_0000_8000_1003);
        xlate("R1 programmed entry", 64'h0000_0000_0000_1abc, 1'b0);
        do_reset();
        check("R1 idle after reset", !rsp_valid && req_ready, $sformatf("v=%0b r=%0b", rsp_valid, req_ready), "v=0 r=1");
        check_after_clear();
    endtask

    task automatic check_after_clear();
        xlate("R1 entry cleared by reset", 64'h0000_0000_0000_1abc, 1'b0);
        check("R1 fault after clear", rsp_fault && rsp_perm == 2'd0, $sformatf("f=%0b p=%0d", rsp_fault, rsp_perm), "f=1 p=0");
    endtask

    task automatic t_perm();
        for (int p = 0; p < 4; p++) put(p, 64'h0000_0012_3400_0000 + 64'(p) * 64'h1000 + 64'(p));
        for (int p = 0; p < 4; p++) begin
            xlate($sformatf("R2 R6 read perm %0d", p), 64'(p) * 64'h1000 + 64'h10, 1'b0);
            xlate($sformatf("R2 R6 write perm %0d", p), 64'(p) * 64'h1000 + 64'h20, 1'b1);
        end
    endtask

    task automatic t_translate();
        put(5, 64'hdead_beef_cafe_5003);
        put(6, 64'h0000_0001_0000_6fff);
        xlate("R3 R5 page 5", 64'h0000_0000_0000_5a5a, 1'b1);
        check("R5 offset merge", rsp_addr == 64'hdead_beef_cafe_5a5a, $sformatf("%h", rsp_addr), "deadbeefcafe5a5a");
        xlate("R3 R5 page 6 low bits dropped", 64'h0000_0000_0000_6001, 1'b0);
    endtask

    task automatic t_range();
        put(7, 64'h0000_0000_0777_7003);
        xlate("R4 last page in window", 64'h0000_0000_0000_7ffc, 1'b0);
        xlate("R4 first page past count", 64'h0000_0000_0000_8000, 1'b0);
        xlate("R4 far above window", 64'hffff_0000_0000_0000, 1'b1);
    endtask

    task automatic t_zero();
        cfg_count = '0;
        xlate("R7 window disabled page 0", 64'h0000_0000_0000_0010, 1'b0);
        xlate("R7 window disabled page 5", 64'h0000_0000_0000_5000, 1'b1);
        cfg_count = CNT_W'(8);
    endtask

    task automatic t_shift();
        cfg_shift = 6'd16;
        put(2, 64'h0000_00ab_cd00_0003);
        xlate("R9 shift 16 page 2", 64'h0000_0000_0002_f00d, 1'b0);
        check("R9 mask width", rsp_mask == 64'hffff, $sformatf("%h", rsp_mask), "ffff");
        xlate("R9 shift 16 past count", 64'h0000_0000_0008_0000, 1'b0);
        cfg_shift = 6'd12;
    endtask

    task automatic t_stall();
        put(3, 64'h0000_0000_3333_3003);
        put(4, 64'h0000_0000_4444_4001);
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h3123; req_write = 1'b0;
        @(negedge clk);
        req_addr = 64'h4456; req_write = 1'b1;
        check("R8 ready drops while stalled", rsp_valid && !req_ready, $sformatf("v=%0b r=%0b", rsp_valid, req_ready), "v=1 r=0");
        repeat (3) @(negedge clk);
        check_rsp("R8 held while stalled", 64'h0000_0000_3333_3123, 64'hfff, 2'd3, 1'b0);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R8 next taken at release", 64'h0000_0000_4444_4456, 64'hfff, 2'd1, 1'b1);
        @(negedge clk);
        check("R8 drains", !rsp_valid, $sformatf("v=%0b", rsp_valid), "v=0");
    endtask

    initial begin
        rst = 1'b1; cfg_shift = 6'd12; cfg_count = CNT_W'(8);
        upd_en = 1'b0; upd_idx = '0; upd_data = '0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; rsp_ready = 1'b1;
        do_reset();
        t_reset();
        t_perm();
        t_translate();
        t_range();
        t_zero();
        t_shift();
        t_stall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule